// File: doc/BRIEF.md
# Instruction Fetch Window Guard

This block sits beside a CPU and watches every instruction fetch it issues. Software programs a lower and an upper address bound, then switches the guard on. From then on, any fetch whose address falls inside the inclusive window raises a trap line. The trap line stays high until the next reset, so the system's trap or reset logic can act on it.

Arming the guard is a one-way step. After the guard is on, software cannot turn it off. Writes to the two bound registers are dropped. The window therefore stays fixed for the rest of the power cycle, whatever code runs afterwards.

All three configuration registers are write-only and are reached through a simple register write port. Register offsets are set by parameters:

| Offset parameter | Default | Register |
|---|---|---|
| `OFS_CTRL` | 0x0 | Control. Bit 0 is the arm bit. |
| `OFS_LO` | 0x4 | Lower bound |
| `OFS_HI` | 0x8 | Upper bound |

Top module: `exec_guard`

## Requirements
- R1: After reset the guard is disarmed, both bounds are zero and `trap` is 0.
- R2: A write to `OFS_CTRL` with bit 0 = 1 arms the guard from the following cycle on. A write with bit 0 = 0 while disarmed leaves it disarmed.
- R3: Once armed, the guard stays armed until reset. A later write of bit 0 = 0 to `OFS_CTRL` has no effect.
- R4: While armed, writes to `OFS_LO` and `OFS_HI` are ignored, so the bounds programmed before arming stay in force.
- R5: While armed, a cycle with `fetch_valid` = 1 and `lo <= fetch_addr <= hi` sets `trap` to 1 at the next clock edge. Both bounds are inclusive.
- R6: An armed fetch whose address is below `lo` or above `hi` does not set `trap`.
- R7: While disarmed, no fetch sets `trap`, whatever its address.
- R8: An address on `fetch_addr` with `fetch_valid` = 0 never sets `trap`.
- R9: If `lo > hi`, the window is empty and no fetch sets `trap`.
- R10: Once `trap` is 1, it stays 1 until reset.
- R11: Writes to offsets other than the three mapped ones change neither the arm state nor the bounds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| fetch_valid | input | 1 | Instruction fetch strobe |
| fetch_addr | input | ADDR_W | Instruction fetch address |
| trap | output | 1 | Sticky execution violation flag |

## Verification
The assertions check the following on every cycle:
- the arm bit never clears (R3);
- the bounds are frozen while the guard is armed (R4);
- `trap` is sticky (R10);
- an armed in-window fetch always traps (R5);
- every rising edge of `trap` follows an armed, valid fetch into a non-empty window (R7, R8, R9).

Because the registers are write-only, only the bench scenarios can show several things from the ports:
- that writes made after arming are really dropped;
- that unmapped offsets and clear writes are harmless;
- how the window decision depends on the address.

The bench shows the address dependence by sweeping every address of a small address space against several windows, including single-address, full-range and inverted windows.

// File: rtl/exec_guard.sv
module exec_guard #(
  parameter int ADDR_W   = 32,
  parameter int REG_AW   = 4,
  parameter int OFS_CTRL = 0,
  parameter int OFS_LO   = 4,
  parameter int OFS_HI   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              trap
);
  localparam logic [REG_AW-1:0] A_CTRL = REG_AW'(OFS_CTRL);
  localparam logic [REG_AW-1:0] A_LO   = REG_AW'(OFS_LO);
  localparam logic [REG_AW-1:0] A_HI   = REG_AW'(OFS_HI);

  logic              armed;
  logic [ADDR_W-1:0] lo, hi;
  logic              wr_ctrl, wr_lo, wr_hi, hit;

  assign wr_ctrl = reg_we && reg_addr == A_CTRL;
  assign wr_lo   = reg_we && reg_addr == A_LO && !armed;
  assign wr_hi   = reg_we && reg_addr == A_HI && !armed;
  assign hit     = armed && fetch_valid && fetch_addr >= lo && fetch_addr <= hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      lo    <= '0;
      hi    <= '0;
      trap  <= 1'b0;
    end else begin
      if (wr_ctrl && reg_wdata[0]) armed <= 1'b1;
      if (wr_lo) lo <= reg_wdata[ADDR_W-1:0];
      if (wr_hi) hi <= reg_wdata[ADDR_W-1:0];
      if (hit)   trap <= 1'b1;
    end
  end
endmodule

// File: rtl/exec_guard_chk.sv
module exec_guard_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              armed,
  input logic [ADDR_W-1:0] lo,
  input logic [ADDR_W-1:0] hi,
  input logic              fetch_valid,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              trap
);
  a_r3_arm_holds: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> armed);

  a_r4_bounds_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> ($stable(lo) && $stable(hi)));

  a_r10_trap_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    trap |=> trap);

  a_r5_hit_traps: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && fetch_valid && lo <= fetch_addr && fetch_addr <= hi) |=> trap);

  a_r7_r8_r9_trap_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (!trap && !(armed && fetch_valid && lo <= hi)) |=> !trap);
endmodule

bind exec_guard exec_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .armed(armed), .lo(lo), .hi(hi),
  .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .trap(trap)
);

// File: tb/exec_guard_test.sv
module exec_guard_test;
  localparam int AW = 6;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [3:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic          fetch_valid = 1'b0;
  logic [AW-1:0] fetch_addr = '0;
  logic          trap;
  int            errors = 0;
  int            checks = 0;

  always #5 clk = ~clk;

  exec_guard #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .fetch_valid(fetch_valid),
    .fetch_addr(fetch_addr), .trap(trap)
  );

  task automatic check(input string req, input logic exp);
    checks++;
    if (trap !== exp) begin
      errors++;
      $display("FAIL %s: trap=%b expected=%b", req, trap, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic wr(input int ofs, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 4'(ofs); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic fetch(input int a, input logic v);
    @(negedge clk);
    fetch_valid = v; fetch_addr = AW'(a);
    @(negedge clk);
    fetch_valid = 1'b0;
  endtask

  task automatic setup(input int l, input int h, input bit arm);
    do_reset();
    wr(4, 32'(l));
    wr(8, 32'(h));
    if (arm) wr(0, 32'h1);
  endtask

  initial begin
    #(200000 * 10);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int wl[6] = '{10, 0, 0, 33, 63, 40};
    int wh[6] = '{20, 63, 0, 33, 63, 12};

    // R1: reset state, and an armed guard with zero bounds catches address 0 only
    do_reset();
    check("R1 reset", 1'b0);
    wr(0, 32'h1);
    fetch(1, 1'b1);
    check("R1 bounds zero", 1'b0);
    fetch(0, 1'b1);
    check("R1 bounds zero hit", 1'b1);

    // R5 R6 R9: address sweeps over several windows
    for (int w = 0; w < 6; w++) begin
      for (int a = 0; a < N; a++) begin
        setup(wl[w], wh[w], 1'b1);
        fetch(a, 1'b1);
        check((wl[w] > wh[w]) ? "R9 empty window" :
              ((a >= wl[w] && a <= wh[w]) ? "R5 inside" : "R6 outside"),
              (a >= wl[w] && a <= wh[w]) ? 1'b1 : 1'b0);
      end
    end

    // R7: disarmed sweep
    setup(0, 63, 1'b0);
    for (int a = 0; a < N; a++) begin
      fetch(a, 1'b1);
      check("R7 disarmed", 1'b0);
    end

    // R8: fetch_valid low
    setup(0, 63, 1'b1);
    for (int a = 0; a < N; a++) begin
      fetch(a, 1'b0);
      check("R8 no valid", 1'b0);
    end

    // R2: bit 0 clear does not arm
    setup(5, 9, 1'b0);
    wr(0, 32'hFFFF_FFFE);
    fetch(7, 1'b1);
    check("R2 bit0 clear", 1'b0);
    wr(0, 32'h1);
    fetch(7, 1'b1);
    check("R2 arm", 1'b1);

    // R3: clear write after arming
    setup(5, 9, 1'b1);
    wr(0, 32'h0);
    fetch(5, 1'b1);
    check("R3 cannot disarm", 1'b1);

    // R4: bounds locked after arming
    setup(5, 9, 1'b1);
    wr(4, 32'd30);
    wr(8, 32'd40);
    fetch(35, 1'b1);
    check("R4 new window ignored", 1'b0);
    fetch(9, 1'b1);
    check("R4 old window kept", 1'b1);

    // R11: unmapped offsets
    setup(5, 9, 1'b0);
    wr(12, 32'h1);
    wr(1, 32'hFFFF_FFFF);
    fetch(6, 1'b1);
    check("R11 no arm", 1'b0);
    wr(2, 32'd0);
    wr(0, 32'h1);
    fetch(5, 1'b1);
    check("R11 bounds kept", 1'b1);

    // R10: sticky
    setup(20, 22, 1'b1);
    fetch(21, 1'b1);
    check("R10 set", 1'b1);
    for (int a = 0; a < 10; a++) begin
      fetch(a, 1'b1);
      check("R10 sticky", 1'b1);
    end
    do_reset();
    check("R1 reset clears trap", 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule